// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block sits between a small host register port and an 8-bit parallel NOR flash. The host stages a 23-bit byte address in three byte-wide registers, then either writes a byte to the data register (program), reads the data register (fetch one flash byte), or writes a request code to the command register (block erase, chip erase, identify, reset). The sequencer expands each request into the series of flash bus cycles the device needs. For commands this includes the two unlock cycles at 0x4555 and 0x5AAA. For program and erase it then polls bit 7 of the device until the operation completes.

Every flash bus cycle has a fixed shape: one setup cycle with chip-enable low, then `PULSE_LEN` cycles with write-enable or output-enable low, then one hold cycle. After that the next request is issued. Block erase targets the base of the sector holding the staged address. The first 64 KB of the device is split into eight 8 KB sectors, and every sector above that is 64 KB. The `busy` output covers the whole sequence. `done` and the two error flags hold until the next request is accepted.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, `busy`, `done`, `timeout_err`, `id_mismatch` and `fl_dq_oe` are 0, and `fl_ce_n`, `fl_we_n` and `fl_oe_n` are 1.
- R2: The flash address of a request is {reg 2 bits 6..0, reg 1, reg 0} (register select 0, 1, 2). Bit 7 written to reg 2 is ignored.
- R3: In every bus cycle chip-enable is low while write-enable or output-enable is low. Write-enable and output-enable are never low together. The data bus is driven only in write cycles, never while output-enable is low.
- R4: A host write to the data register (select 3) issues four writes: 0xAA@0x4555, 0x55@0x5AAA, 0xA0@0x4555, then data@address. The block then reads the address until bit 7 equals bit 7 of the data.
- R5: Command code 0x01 written to select 4 (block erase) issues six writes: 0xAA@0x4555, 0x55@0x5AAA, 0x80@0x4555, 0xAA@0x4555, 0x55@0x5AAA, 0x30@sector base. The base clears address bits 12..0 when the address is below 0x010000, and bits 15..0 otherwise. The block then polls the base until bit 7 reads 1.
- R6: Command code 0x02 (chip erase) issues the same first five writes, then 0x10@0x4555. The block then polls address 0 until bit 7 reads 1.
- R7: Command code 0x03 (identify) issues 0xAA@0x4555, 0x55@0x5AAA, 0x90@0x4555, one read at address 0x000001, then 0xF0@0x4555. The byte read appears on `reg_rdata`, and `id_mismatch` is 1 exactly when that byte differs from 0x7E.
- R8: Command code 0x04 (reset) issues the single write 0xF0@0x4555.
- R9: A host read of the data register (select 3) issues one read at the staged address. The byte appears on `reg_rdata` when `done` rises.
- R10: A request made of N bus cycles holds `busy` high for exactly N*(PULSE_LEN+4) clock cycles, counted from the edge that accepts it. `done` is 1 once `busy` falls.
- R11: If TIMEOUT_POLLS poll reads all fail, the sequence ends with `timeout_err` and `done` both 1. The next accepted request clears `timeout_err`.
- R12: Requests (data write, data read, command write) that arrive while `busy` is high are ignored and add no bus cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 3 | Host register select: 0,1,2 address bytes, 3 data, 4 command |
| reg_wr | input | 1 | Host write strobe |
| reg_rd | input | 1 | Host read strobe (meaningful for select 3) |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Last byte fetched by a data read or identify |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Last sequence finished |
| timeout_err | output | 1 | Last sequence ended by poll timeout |
| id_mismatch | output | 1 | Last identify returned a byte other than 0x7E |
| fl_addr | output | 23 | Flash byte address |
| fl_dq_out | output | 8 | Flash write data |
| fl_dq_oe | output | 1 | Drive enable for fl_dq_out |
| fl_dq_in | input | 8 | Flash read data |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_we_n | output | 1 | Flash write enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |

## Verification
Each flash bus cycle takes PULSE_LEN+4 clocks from issue to the next issue. A request of N cycles therefore keeps `busy` high for N*(PULSE_LEN+4) clocks after the accepting edge. The bench counts `busy` at every falling edge and compares the count with that product. `reg_rdata` and the flags are registered on the acknowledge that closes the final cycle, so the bench samples them on the first falling edge with `busy` low. The flash model records every write-enable rising edge and every output-enable rising edge, which gives the exact cycle list and poll count of each sequence.

// File: rtl/flseq_pkg.sv
package flseq_pkg;
  typedef enum logic [2:0] {
    OP_RESET, OP_PROG, OP_READ, OP_BERASE, OP_CERASE, OP_IDENT
  } op_e;

  localparam logic [15:0] UNLOCK_A1 = 16'h4555;
  localparam logic [15:0] UNLOCK_A2 = 16'h5AAA;
  localparam logic [7:0]  UNLOCK_D1 = 8'hAA;
  localparam logic [7:0]  UNLOCK_D2 = 8'h55;
  localparam logic [7:0]  CMD_ID     = 8'h90;
  localparam logic [7:0]  CMD_PROG   = 8'hA0;
  localparam logic [7:0]  CMD_ESETUP = 8'h80;
  localparam logic [7:0]  CMD_CERASE = 8'h10;
  localparam logic [7:0]  CMD_BERASE = 8'h30;
  localparam logic [7:0]  CMD_RESET  = 8'hF0;
  localparam logic [15:0] ID_ADDR    = 16'h0001;

  localparam logic [2:0] SEL_DATA = 3'd3;
  localparam logic [2:0] SEL_CMD  = 3'd4;
  localparam logic [7:0] HC_BERASE = 8'h01;
  localparam logic [7:0] HC_CERASE = 8'h02;
  localparam logic [7:0] HC_IDENT  = 8'h03;
  localparam logic [7:0] HC_RESET  = 8'h04;
endpackage

// File: rtl/flseq_sector.sv
module flseq_sector #(
  parameter int AW        = 23,
  parameter int SMALL_LOG = 13,
  parameter int LARGE_LOG = 16
) (
  input  logic [AW-1:0] addr,
  output logic [AW-1:0] base
);
  localparam logic [AW-1:0] SMALL_MASK = ~((AW'(1) << SMALL_LOG) - AW'(1));
  localparam logic [AW-1:0] LARGE_MASK = ~((AW'(1) << LARGE_LOG) - AW'(1));

  always_comb begin
    if (addr[AW-1:LARGE_LOG] == '0) base = addr & SMALL_MASK;
    else                            base = addr & LARGE_MASK;
  end
endmodule

// File: rtl/flseq_bus.sv
module flseq_bus #(
  parameter int AW        = 23,
  parameter int PULSE_LEN = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic          req_rd,
  input  logic [AW-1:0] req_addr,
  input  logic [7:0]    req_data,
  output logic          ack,
  output logic [7:0]    rdata,
  output logic [AW-1:0] fl_addr,
  output logic [7:0]    fl_dq_out,
  output logic          fl_dq_oe,
  input  logic [7:0]    fl_dq_in,
  output logic          fl_ce_n,
  output logic          fl_we_n,
  output logic          fl_oe_n
);
  localparam int CW = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1;

  typedef enum logic [1:0] {B_IDLE, B_SETUP, B_ACT, B_HOLD} bst_e;
  bst_e          st;
  logic [CW-1:0] cnt;
  logic          rd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= B_IDLE; cnt <= '0; rd_q <= 1'b0; ack <= 1'b0; rdata <= '0;
      fl_addr <= '0; fl_dq_out <= '0; fl_dq_oe <= 1'b0;
      fl_ce_n <= 1'b1; fl_we_n <= 1'b1; fl_oe_n <= 1'b1;
    end else begin
      ack <= 1'b0;
      case (st)
        B_IDLE: if (req) begin
          fl_addr   <= req_addr;
          fl_dq_out <= req_data;
          fl_dq_oe  <= ~req_rd;
          rd_q      <= req_rd;
          fl_ce_n   <= 1'b0;
          st        <= B_SETUP;
        end
        B_SETUP: begin
          cnt <= '0;
          if (rd_q) fl_oe_n <= 1'b0;
          else      fl_we_n <= 1'b0;
          st <= B_ACT;
        end
        B_ACT: begin
          if (cnt == CW'(PULSE_LEN - 1)) begin
            fl_we_n <= 1'b1;
            fl_oe_n <= 1'b1;
            if (rd_q) rdata <= fl_dq_in;
            st <= B_HOLD;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        default: begin
          fl_ce_n  <= 1'b1;
          fl_dq_oe <= 1'b0;
          ack      <= 1'b1;
          st       <= B_IDLE;
        end
      endcase
    end
  end

  assert_we_oe_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
    !(!fl_we_n && !fl_oe_n));
  assert_strobe_needs_ce_R3: assert property (@(posedge clk) disable iff (rst)
    (!fl_we_n || !fl_oe_n) |-> !fl_ce_n);
  assert_no_contention_R3: assert property (@(posedge clk) disable iff (rst)
    fl_dq_oe |-> fl_oe_n);
  assert_ack_single_R10: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack);
endmodule

// File: rtl/flseq_ctrl.sv
module flseq_ctrl import flseq_pkg::*; #(
  parameter int         AW            = 23,
  parameter int         TIMEOUT_POLLS = 4096,
  parameter logic [7:0] ID_VALUE      = 8'h7E
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  op_e           start_op,
  input  logic [AW-1:0] start_addr,
  input  logic [7:0]    start_data,
  output logic          bus_req,
  output logic          bus_rd,
  output logic [AW-1:0] bus_addr,
  output logic [7:0]    bus_data,
  input  logic          bus_ack,
  input  logic [7:0]    bus_rdata,
  output logic          busy,
  output logic          done,
  output logic          tmo_err,
  output logic          id_mismatch,
  output logic [7:0]    rd_byte
);
  localparam int PCW = $clog2(TIMEOUT_POLLS + 1);
  localparam logic [AW-1:0] UA1 = {{(AW-16){1'b0}}, UNLOCK_A1};
  localparam logic [AW-1:0] UA2 = {{(AW-16){1'b0}}, UNLOCK_A2};
  localparam logic [AW-1:0] IDA = {{(AW-16){1'b0}}, ID_ADDR};

  typedef enum logic [1:0] {C_IDLE, C_ISSUE, C_WAIT} cst_e;
  cst_e           st;
  op_e            op_q;
  logic [AW-1:0]  addr_q, sect_base, poll_addr, st_addr;
  logic [7:0]     data_q, st_data;
  logic [2:0]     step;
  logic           polling, st_rd, st_last, need_poll, poll_bit;
  logic [PCW-1:0] poll_cnt;

  flseq_sector #(.AW(AW)) u_sector (.addr(addr_q), .base(sect_base));

  always_comb begin
    st_rd = 1'b0; st_last = 1'b0; st_addr = UA1; st_data = UNLOCK_D1;
    case (op_q)
      OP_RESET: begin st_data = CMD_RESET; st_last = 1'b1; end
      OP_READ:  begin st_rd = 1'b1; st_addr = addr_q; st_last = 1'b1; end
      default: begin
        case (step)
          3'd0: ;
          3'd1: begin st_addr = UA2; st_data = UNLOCK_D2; end
          3'd2: st_data = (op_q == OP_PROG)  ? CMD_PROG :
                          (op_q == OP_IDENT) ? CMD_ID : CMD_ESETUP;
          3'd3: begin
            if (op_q == OP_PROG) begin
              st_addr = addr_q; st_data = data_q; st_last = 1'b1;
            end else if (op_q == OP_IDENT) begin
              st_rd = 1'b1; st_addr = IDA;
            end
          end
          3'd4: begin
            if (op_q == OP_IDENT) begin st_data = CMD_RESET; st_last = 1'b1; end
            else begin st_addr = UA2; st_data = UNLOCK_D2; end
          end
          default: begin
            st_last = 1'b1;
            if (op_q == OP_BERASE) begin st_addr = sect_base; st_data = CMD_BERASE; end
            else st_data = CMD_CERASE;
          end
        endcase
      end
    endcase
  end

  assign need_poll = (op_q == OP_PROG) || (op_q == OP_BERASE) || (op_q == OP_CERASE);
  assign poll_addr = (op_q == OP_PROG) ? addr_q : (op_q == OP_BERASE) ? sect_base : '0;
  assign poll_bit  = (op_q == OP_PROG) ? data_q[7] : 1'b1;

  assign bus_req  = (st == C_ISSUE);
  assign bus_rd   = polling | st_rd;
  assign bus_addr = polling ? poll_addr : st_addr;
  assign bus_data = st_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= C_IDLE; op_q <= OP_RESET; addr_q <= '0; data_q <= '0; step <= '0;
      polling <= 1'b0; poll_cnt <= '0; busy <= 1'b0; done <= 1'b0;
      tmo_err <= 1'b0; id_mismatch <= 1'b0; rd_byte <= '0;
    end else begin
      case (st)
        C_IDLE: if (start) begin
          op_q <= start_op; addr_q <= start_addr; data_q <= start_data;
          step <= '0; polling <= 1'b0; poll_cnt <= '0;
          busy <= 1'b1; done <= 1'b0; tmo_err <= 1'b0; id_mismatch <= 1'b0;
          st <= C_ISSUE;
        end
        C_ISSUE: st <= C_WAIT;
        default: if (bus_ack) begin
          if (polling) begin
            if (bus_rdata[7] == poll_bit) begin
              busy <= 1'b0; done <= 1'b1; st <= C_IDLE;
            end else if (poll_cnt == PCW'(TIMEOUT_POLLS - 1)) begin
              tmo_err <= 1'b1; busy <= 1'b0; done <= 1'b1; st <= C_IDLE;
            end else begin
              poll_cnt <= poll_cnt + PCW'(1); st <= C_ISSUE;
            end
          end else begin
            if (st_rd) begin
              rd_byte <= bus_rdata;
              if (op_q == OP_IDENT) id_mismatch <= (bus_rdata != ID_VALUE);
            end
            if (!st_last) begin
              step <= step + 3'd1; st <= C_ISSUE;
            end else if (need_poll) begin
              polling <= 1'b1; st <= C_ISSUE;
            end else begin
              busy <= 1'b0; done <= 1'b1; st <= C_IDLE;
            end
          end
        end
      endcase
    end
  end

  assert_done_not_busy_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  assert_timeout_ends_seq_R11: assert property (@(posedge clk) disable iff (rst)
    tmo_err |-> done);
  assert_op_held_R12: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(op_q) && $stable(addr_q) && $stable(data_q)));
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq import flseq_pkg::*; #(
  parameter int         ADDR_W        = 23,
  parameter int         PULSE_LEN     = 2,
  parameter int         TIMEOUT_POLLS = 4096,
  parameter logic [7:0] ID_VALUE      = 8'h7E
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        reg_sel,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              busy,
  output logic              done,
  output logic              timeout_err,
  output logic              id_mismatch,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [7:0]        fl_dq_out,
  output logic              fl_dq_oe,
  input  logic [7:0]        fl_dq_in,
  output logic              fl_ce_n,
  output logic              fl_we_n,
  output logic              fl_oe_n
);
  localparam int HI_W = ADDR_W - 16;

  logic [7:0]        a_lo, a_mid;
  logic [HI_W-1:0]   a_hi;
  logic              start, bus_req, bus_rd, bus_ack;
  op_e               start_op;
  logic [ADDR_W-1:0] bus_addr;
  logic [7:0]        bus_data, bus_rdata;
  logic              unused_hi_bits;

  assign unused_hi_bits = ^reg_wdata[7:HI_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      a_lo <= '0; a_mid <= '0; a_hi <= '0;
    end else if (reg_wr) begin
      case (reg_sel)
        3'd0: a_lo  <= reg_wdata;
        3'd1: a_mid <= reg_wdata;
        3'd2: a_hi  <= reg_wdata[HI_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    start = 1'b0; start_op = OP_RESET;
    if (!busy) begin
      if (reg_wr && reg_sel == SEL_DATA) begin
        start = 1'b1; start_op = OP_PROG;
      end else if (reg_rd && reg_sel == SEL_DATA) begin
        start = 1'b1; start_op = OP_READ;
      end else if (reg_wr && reg_sel == SEL_CMD) begin
        case (reg_wdata)
          HC_BERASE: begin start = 1'b1; start_op = OP_BERASE; end
          HC_CERASE: begin start = 1'b1; start_op = OP_CERASE; end
          HC_IDENT:  begin start = 1'b1; start_op = OP_IDENT;  end
          HC_RESET:  begin start = 1'b1; start_op = OP_RESET;  end
          default: ;
        endcase
      end
    end
  end

  flseq_ctrl #(.AW(ADDR_W), .TIMEOUT_POLLS(TIMEOUT_POLLS), .ID_VALUE(ID_VALUE)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .start_op(start_op),
    .start_addr({a_hi, a_mid, a_lo}), .start_data(reg_wdata),
    .bus_req(bus_req), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_data(bus_data),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata), .busy(busy), .done(done),
    .tmo_err(timeout_err), .id_mismatch(id_mismatch), .rd_byte(reg_rdata)
  );

  flseq_bus #(.AW(ADDR_W), .PULSE_LEN(PULSE_LEN)) u_bus (
    .clk(clk), .rst(rst), .req(bus_req), .req_rd(bus_rd), .req_addr(bus_addr),
    .req_data(bus_data), .ack(bus_ack), .rdata(bus_rdata), .fl_addr(fl_addr),
    .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe), .fl_dq_in(fl_dq_in),
    .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n)
  );

  assert_bus_only_when_busy_R10: assert property (@(posedge clk) disable iff (rst)
    !fl_ce_n |-> busy);
  assert_busy_blocks_start_R12: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && reg_wr && reg_sel == SEL_CMD) |=> busy || done);
endmodule

// File: tb/test_flash_cmd_seq.sv
module test_flash_cmd_seq;
  localparam int P   = 2;
  localparam int CYC = P + 4;
  localparam int TMO = 8;

  logic        clk = 1'b0, rst = 1'b1;
  logic [2:0]  reg_sel = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]  reg_wdata = '0, reg_rdata;
  logic        busy, done, timeout_err, id_mismatch;
  logic [22:0] fl_addr;
  logic [7:0]  fl_dq_out, fl_dq_in;
  logic        fl_dq_oe, fl_ce_n, fl_we_n, fl_oe_n;

  always #2 clk = ~clk;

  flash_cmd_seq #(.PULSE_LEN(P), .TIMEOUT_POLLS(TMO)) i_flash_cmd_seq (
    .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy), .done(done),
    .timeout_err(timeout_err), .id_mismatch(id_mismatch), .fl_addr(fl_addr),
    .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe), .fl_dq_in(fl_dq_in),
    .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n));

  // flash model
  logic [7:0]  mem [0:255];
  logic [22:0] log_a [0:15];
  logic [7:0]  log_d [0:15];
  int          nw = 0, nr = 0, pending = 0;
  logic        tgt7 = 1'b0, autosel = 1'b0, arm = 1'b0;
  logic [7:0]  dev_id = 8'h7E;
  logic [22:0] last_rd = '0;
  int          total = 0, fails = 0;

  assign fl_dq_in = (pending > 0) ? {~tgt7, 7'h00} :
                    (autosel && fl_addr == 23'h1) ? dev_id : mem[fl_addr[7:0]];

  always @(posedge fl_we_n) if (!fl_ce_n) begin
    log_a[nw[3:0]] = fl_addr;
    log_d[nw[3:0]] = fl_dq_out;
    nw = nw + 1;
    if (arm) begin
      mem[fl_addr[7:0]] = fl_dq_out; arm = 1'b0;
    end else if (fl_dq_out == 8'hA0 && fl_addr == 23'h4555) arm = 1'b1;
    else if (fl_dq_out == 8'h90 && fl_addr == 23'h4555) autosel = 1'b1;
    else if (fl_dq_out == 8'hF0) autosel = 1'b0;
    else if (fl_dq_out == 8'h30 || (fl_dq_out == 8'h10 && fl_addr == 23'h4555))
      for (int i = 0; i < 256; i++) mem[i] = 8'hFF;
  end

  always @(posedge fl_oe_n) if (!fl_ce_n) begin
    nr = nr + 1;
    last_rd = fl_addr;
    if (pending > 0) pending = pending - 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic strobe(input logic [2:0] sel, input logic [7:0] d, input logic is_rd);
    @(negedge clk);
    reg_sel = sel; reg_wdata = d; reg_wr = ~is_rd; reg_rd = is_rd;
    @(negedge clk);
    reg_wr = 1'b0; reg_rd = 1'b0;
  endtask

  task automatic wait_idle(output int cnt);
    cnt = 0;
    while (busy && cnt < 20000) begin
      cnt++;
      @(negedge clk);
    end
  endtask

  task automatic set_addr(input logic [7:0] lo, input logic [7:0] mid, input logic [7:0] hi);
    strobe(3'd0, lo, 1'b0);
    strobe(3'd1, mid, 1'b0);
    strobe(3'd2, hi, 1'b0);
  endtask

  task automatic t_reset_state;
    chk("R1 busy", busy, 0);  chk("R1 done", done, 0);
    chk("R1 tmo", timeout_err, 0); chk("R1 idm", id_mismatch, 0);
    chk("R1 ce", fl_ce_n, 1); chk("R1 we", fl_we_n, 1);
    chk("R1 oe", fl_oe_n, 1); chk("R1 dqoe", fl_dq_oe, 0);
  endtask

  task automatic t_reset_cmd;
    int c;
    nw = 0;
    strobe(3'd4, 8'h04, 1'b0);
    wait_idle(c);
    chk("R8 writes", nw, 1);
    chk("R8 addr", log_a[0], 23'h4555);
    chk("R8 data", log_d[0], 8'hF0);
    chk("R10 reset busy cycles", c, CYC);
    chk("R10 done", done, 1);
  endtask

  task automatic t_program;
    int c;
    set_addr(8'h3C, 8'h12, 8'hFF);
    nw = 0; nr = 0; pending = 2; tgt7 = 1'b1;
    strobe(3'd3, 8'hC5, 1'b0);
    wait_idle(c);
    chk("R4 writes", nw, 4);
    chk("R4 w0", {log_a[0], log_d[0]}, {23'h4555, 8'hAA});
    chk("R4 w1", {log_a[1], log_d[1]}, {23'h5AAA, 8'h55});
    chk("R4 w2", {log_a[2], log_d[2]}, {23'h4555, 8'hA0});
    chk("R2 program address", log_a[3], 23'h7F123C);
    chk("R4 data", log_d[3], 8'hC5);
    chk("R4 polls", nr, 3);
    chk("R4 poll addr", last_rd, 23'h7F123C);
    chk("R10 program busy cycles", c, 7 * CYC);
    chk("R4 done/tmo", {done, timeout_err}, 2'b10);
  endtask

  task automatic t_read;
    int c;
    nr = 0; nw = 0;
    strobe(3'd3, 8'h00, 1'b1);
    wait_idle(c);
    chk("R9 reads", nr, 1);
    chk("R9 writes", nw, 0);
    chk("R9 rdata", reg_rdata, 8'hC5);
    chk("R10 read busy cycles", c, CYC);
  endtask

  task automatic t_berase(input logic [7:0] lo, input logic [7:0] mid,
                          input logic [7:0] hi, input logic [22:0] base, input int busy_polls);
    int c;
    set_addr(lo, mid, hi);
    nw = 0; nr = 0; pending = busy_polls; tgt7 = 1'b1;
    strobe(3'd4, 8'h01, 1'b0);
    // requests while busy must be dropped
    strobe(3'd4, 8'h04, 1'b0);
    strobe(3'd3, 8'h11, 1'b0);
    strobe(3'd3, 8'h00, 1'b1);
    wait_idle(c);
    repeat (20) @(negedge clk);
    chk("R12 still idle", busy, 0);
    chk("R12 writes", nw, 6);
    chk("R5 w2", {log_a[2], log_d[2]}, {23'h4555, 8'h80});
    chk("R5 w3", {log_a[3], log_d[3]}, {23'h4555, 8'hAA});
    chk("R5 w4", {log_a[4], log_d[4]}, {23'h5AAA, 8'h55});
    chk("R5 final", {log_a[5], log_d[5]}, {base, 8'h30});
    chk("R5 polls", nr, busy_polls + 1);
    chk("R5 poll addr", last_rd, base);
    chk("R5 erased", mem[8'h3C], 8'hFF);
  endtask

  task automatic t_cerase;
    int c;
    nw = 0; nr = 0; pending = 1; tgt7 = 1'b1;
    strobe(3'd4, 8'h02, 1'b0);
    wait_idle(c);
    chk("R6 writes", nw, 6);
    chk("R6 w2", log_d[2], 8'h80);
    chk("R6 final", {log_a[5], log_d[5]}, {23'h4555, 8'h10});
    chk("R6 poll addr", last_rd, 23'h0);
    chk("R6 polls", nr, 2);
  endtask

  task automatic t_ident(input logic [7:0] id, input logic exp_mis);
    int c;
    dev_id = id; nw = 0; nr = 0; pending = 0;
    strobe(3'd4, 8'h03, 1'b0);
    wait_idle(c);
    chk("R7 writes", nw, 4);
    chk("R7 w2", {log_a[2], log_d[2]}, {23'h4555, 8'h90});
    chk("R7 exit", {log_a[3], log_d[3]}, {23'h4555, 8'hF0});
    chk("R7 read addr", last_rd, 23'h1);
    chk("R7 rdata", reg_rdata, id);
    chk("R7 mismatch", id_mismatch, exp_mis);
    chk("R10 ident busy cycles", c, 5 * CYC);
  endtask

  task automatic t_timeout;
    int c;
    set_addr(8'h10, 8'h00, 8'h00);
    nw = 0; nr = 0; pending = 100000; tgt7 = 1'b0;
    strobe(3'd3, 8'h40, 1'b0);
    wait_idle(c);
    chk("R11 poll count", nr, TMO);
    chk("R11 flags", {done, timeout_err}, 2'b11);
    pending = 0;
    strobe(3'd4, 8'h04, 1'b0);
    wait_idle(c);
    chk("R11 cleared", timeout_err, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset_state();
    t_reset_cmd();
    t_program();
    t_read();
    t_berase(8'hBC, 8'h2A, 8'h00, 23'h002000, 2);
    t_berase(8'h34, 8'h12, 8'h35, 23'h350000, 3);
    t_cerase();
    t_ident(8'h7E, 1'b0);
    t_ident(8'h5A, 1'b1);
    t_timeout();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
    $finish;
  end
endmodule